// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Register Machine

This block is a small sequential processor. Its data path is 16 bits wide and its instructions are 32 bits wide. It holds thirty-two general registers and one extra register that receives the upper half of a product. It also has a 16-word program store, a 16-word scratch data store and four condition flags. A six-state control machine runs each instruction in a fixed order: fetch, execute, a settling delay, program-counter update and a halt check.

The program store is filled through a write port before `start` is pulsed. After that the core runs on its own until it reaches the halt opcode. Data enters through `din`, which can only be copied into the scratch store. Results leave through the registered `dout` port, which is loaded from the scratch store.

Top module: `mc16_core`

## Requirements
- R1: While `rst` is high and right after it, `fsm_state` is 0 (idle), `pc` is 0, `dout` is 0, `flags` is 0 and `halted` is 0. Reset also clears all registers.
- R2: `fsm_state` encodes states as idle=0, fetch=1, execute=2, delay=3, next=4 and halt-check=5. The core stays in idle until it samples `start` high, and then it moves to fetch.
- R3: Each instruction passes through fetch (1 cycle), execute (1), delay (DELAY_CYCLES, 4 by default), next (1) and halt-check (1). After halt-check the core returns to fetch.
- R4: The instruction word has these fields: [31:27] opcode, [26:22] destination, [21:17] source A, [16] immediate select, [15:11] source B and [15:0] immediate. When bit 16 is 1, operand B is the immediate. When bit 16 is 0, operand B is the register named by [15:11]. Opcodes are 0 MOVSPR (dest = upper-product register), 1 MOV (dest = B), 2 ADD, 3 SUB, 4 MUL, 5 OR, 6 AND, 7 XOR, 8 XNOR, 9 NAND, 10 NOR, 11 NOT (dest = ~B), 12 STR (data[imm[3:0]] = A), 13 STIN (data[imm[3:0]] = din), 14 OUT (dout = data[imm[3:0]]), 15 LDR (dest = data[imm[3:0]]), 16 JMP, 17 JC, 18 JNC, 19 JS, 20 JNS, 21 JZ, 22 JNZ, 23 JV, 24 JNV, 25 to 30 no operation, and 31 HALT.
- R5: The `flags` output holds overflow in bit 3, sign in bit 2, carry in bit 1 and zero in bit 0. ADD sets carry to the carry-out and overflow to the signed overflow. SUB sets carry to the borrow (A < B unsigned) and overflow to the signed overflow. Every opcode from 2 to 11 sets zero to (result == 0) and sign to result bit 15. Only opcodes 2 to 11 change the flags.
- R6: MUL writes the low 16 bits of A*B to the destination and the high 16 bits to the upper-product register. It sets carry when the high half is nonzero and clears overflow. MOVSPR copies the upper-product register into the destination.
- R7: The logic opcodes (5 to 11) compute bitwise results and clear carry and overflow.
- R8: STR, STIN, LDR and OUT move data between the registers, the data store, `din` and `dout`. `dout` changes only as a result of an OUT. MOV does not alter the flags.
- R9: Jumps use target imm[3:0]. JMP is always taken. Each conditional jump is taken only when its flag matches (set or clear) the value held when the jump executes. Jumps do not change the flags.
- R10: HALT leaves `pc` at the halt's own address and sets `halted`. The core stays in halt-check, ignoring `start`, until reset.
- R11: `pc` changes only at the end of the next state. It becomes pc+1, or the target when a jump is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Leaves idle and begins fetching |
| imem_we | input | 1 | Program store write enable |
| imem_addr | input | 4 | Program store write address |
| imem_wdata | input | 32 | Program store write data |
| din | input | 16 | External data input |
| dout | output | 16 | Registered external data output |
| flags | output | 4 | {overflow, sign, carry, zero} |
| pc | output | 4 | Program counter |
| halted | output | 1 | Halt reached |
| fsm_state | output | 3 | Control state code |

## Verification
The bound checker checks the following on every cycle: the order of the states, the exact length of the delay, that `pc` holds outside the next state, that `flags` and `dout` move only from the execute state, that idle holds while `start` is low, and that a halt is permanent. Only the bench's programs can show the data results. These are the arithmetic values and the carry, borrow and overflow flags, the product halves, the bitwise operations, the operand selection by the immediate bit, and the data path from `din` through memory to `dout`. The programs also show which conditional jumps are taken and which fall through.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int XLEN = 16;
  localparam int IW   = 32;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_EXEC  = 3'd2,
    ST_DELAY = 3'd3,
    ST_NEXT  = 3'd4,
    ST_HCHK  = 3'd5
  } state_t;

  typedef enum logic [4:0] {
    OP_MOVSPR = 5'd0,
    OP_MOV    = 5'd1,
    OP_ADD    = 5'd2,
    OP_SUB    = 5'd3,
    OP_MUL    = 5'd4,
    OP_OR     = 5'd5,
    OP_AND    = 5'd6,
    OP_XOR    = 5'd7,
    OP_XNOR   = 5'd8,
    OP_NAND   = 5'd9,
    OP_NOR    = 5'd10,
    OP_NOT    = 5'd11,
    OP_STR    = 5'd12,
    OP_STIN   = 5'd13,
    OP_OUT    = 5'd14,
    OP_LDR    = 5'd15,
    OP_JMP    = 5'd16,
    OP_JC     = 5'd17,
    OP_JNC    = 5'd18,
    OP_JS     = 5'd19,
    OP_JNS    = 5'd20,
    OP_JZ     = 5'd21,
    OP_JNZ    = 5'd22,
    OP_JV     = 5'd23,
    OP_JNV    = 5'd24,
    OP_HALT   = 5'd31
  } opcode_t;

  typedef struct packed {
    logic ovf;
    logic sign;
    logic carry;
    logic zero;
  } flags_t;

  typedef struct packed {
    logic [4:0]      op;
    logic [4:0]      rd;
    logic [4:0]      rs1;
    logic            imm_sel;
    logic [XLEN-1:0] imm;
  } instr_t;
endpackage

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
(
  input  logic [4:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic [XLEN-1:0] hi,
  output flags_t          fl,
  output logic            upd
);
  logic [XLEN:0]     sum;
  logic [XLEN:0]     dif;
  logic [2*XLEN-1:0] prod;

  assign sum  = {1'b0, a} + {1'b0, b};
  assign dif  = {1'b0, a} - {1'b0, b};
  assign prod = a * b;

  always_comb begin
    res      = '0;
    hi       = '0;
    fl.carry = 1'b0;
    fl.ovf   = 1'b0;
    upd      = 1'b1;
    case (op)
      OP_ADD: begin
        res      = sum[XLEN-1:0];
        fl.carry = sum[XLEN];
        fl.ovf   = (a[XLEN-1] == b[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
      end
      OP_SUB: begin
        res      = dif[XLEN-1:0];
        fl.carry = dif[XLEN];
        fl.ovf   = (a[XLEN-1] != b[XLEN-1]) && (dif[XLEN-1] != a[XLEN-1]);
      end
      OP_MUL: begin
        res      = prod[XLEN-1:0];
        hi       = prod[2*XLEN-1:XLEN];
        fl.carry = |prod[2*XLEN-1:XLEN];
      end
      OP_OR:   res = a | b;
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_XNOR: res = ~(a ^ b);
      OP_NAND: res = ~(a & b);
      OP_NOR:  res = ~(a | b);
      OP_NOT:  res = ~b;
      default: upd = 1'b0;
    endcase
    fl.zero = (res == '0);
    fl.sign = res[XLEN-1];
  end
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile
  import mc16_pkg::*;
#(
  parameter  int NUM_REGS = 32,
  localparam int RA_W     = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RA_W-1:0] ra_a,
  input  logic [RA_W-1:0] ra_b,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  input  logic            we,
  input  logic [RA_W-1:0] wa,
  input  logic [XLEN-1:0] wd,
  input  logic            spr_we,
  input  logic [XLEN-1:0] spr_wd,
  output logic [XLEN-1:0] spr_q
);
  logic [XLEN-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      spr_q <= '0;
    end else begin
      if (we)     regs[wa] <= wd;
      if (spr_we) spr_q    <= spr_wd;
    end
  end

  assign rd_a = regs[ra_a];
  assign rd_b = regs[ra_b];
endmodule

// File: rtl/mc16_imem.sv
module mc16_imem
  import mc16_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [IW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [IW-1:0] rq
);
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
#(
  parameter int IA_W         = 4,
  parameter int DELAY_CYCLES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            is_halt,
  input  logic            jump_take,
  input  logic [IA_W-1:0] jump_tgt,
  output state_t          state,
  output logic [IA_W-1:0] pc,
  output logic            halted
);
  localparam int            CW   = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

  state_t          st_q, st_d;
  logic [CW-1:0]   cnt_q;
  logic [IA_W-1:0] pc_q;
  logic            halted_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start) st_d = ST_FETCH;
      ST_FETCH: st_d = ST_EXEC;
      ST_EXEC:  st_d = ST_DELAY;
      ST_DELAY: if (cnt_q == LAST) st_d = ST_NEXT;
      ST_NEXT:  st_d = ST_HCHK;
      ST_HCHK:  if (!halted_q) st_d = ST_FETCH;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_DELAY) cnt_q <= cnt_q + 1'b1;
      else                  cnt_q <= '0;
      if (st_q == ST_NEXT) begin
        if (is_halt)        halted_q <= 1'b1;
        else if (jump_take) pc_q     <= jump_tgt;
        else                pc_q     <= pc_q + 1'b1;
      end
    end
  end

  assign state  = st_q;
  assign pc     = pc_q;
  assign halted = halted_q;
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter  int NUM_REGS     = 32,
  parameter  int IMEM_DEPTH   = 16,
  parameter  int DMEM_DEPTH   = 16,
  parameter  int DELAY_CYCLES = 4,
  localparam int IA_W         = $clog2(IMEM_DEPTH),
  localparam int DA_W         = $clog2(DMEM_DEPTH),
  localparam int RA_W         = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            imem_we,
  input  logic [IA_W-1:0] imem_addr,
  input  logic [IW-1:0]   imem_wdata,
  input  logic [XLEN-1:0] din,
  output logic [XLEN-1:0] dout,
  output logic [3:0]      flags,
  output logic [IA_W-1:0] pc,
  output logic            halted,
  output logic [2:0]      fsm_state
);
  state_t          st;
  logic [IW-1:0]   ir_raw;
  instr_t          ir;
  logic [XLEN-1:0] ra_val, rb_val, opb, spr_val;
  logic [XLEN-1:0] alu_res, alu_hi;
  flags_t          alu_fl, flags_q;
  logic            alu_upd;
  logic            rf_we, spr_we, exec;
  logic [XLEN-1:0] rf_wd;
  logic [XLEN-1:0] dmem [DMEM_DEPTH];
  logic [DA_W-1:0] daddr;
  logic [XLEN-1:0] dmem_rd;
  logic [XLEN-1:0] dout_q;
  logic            jmp_q, jmp_d;

  mc16_imem #(.DEPTH(IMEM_DEPTH)) imem_i (
    .clk(clk), .we(imem_we), .wa(imem_addr), .wd(imem_wdata),
    .re(st == ST_FETCH), .ra(pc), .rq(ir_raw)
  );

  assign ir    = instr_t'(ir_raw);
  assign exec  = (st == ST_EXEC);
  assign daddr = ir.imm[DA_W-1:0];

  mc16_regfile #(.NUM_REGS(NUM_REGS)) rf_i (
    .clk(clk), .rst(rst),
    .ra_a(ir.rs1[RA_W-1:0]), .ra_b(ir.imm[XLEN-1 -: RA_W]),
    .rd_a(ra_val), .rd_b(rb_val),
    .we(rf_we), .wa(ir.rd[RA_W-1:0]), .wd(rf_wd),
    .spr_we(spr_we), .spr_wd(alu_hi), .spr_q(spr_val)
  );

  assign opb = ir.imm_sel ? ir.imm : rb_val;

  mc16_alu alu_i (
    .op(ir.op), .a(ra_val), .b(opb),
    .res(alu_res), .hi(alu_hi), .fl(alu_fl), .upd(alu_upd)
  );

  assign dmem_rd = dmem[daddr];

  always_comb begin
    rf_we = 1'b0;
    rf_wd = alu_res;
    case (ir.op)
      OP_MOVSPR: begin rf_we = exec; rf_wd = spr_val; end
      OP_MOV:    begin rf_we = exec; rf_wd = opb;     end
      OP_LDR:    begin rf_we = exec; rf_wd = dmem_rd; end
      default:   rf_we = exec && alu_upd;
    endcase
  end

  assign spr_we = exec && (ir.op == OP_MUL);

  always_comb begin
    case (ir.op)
      OP_JMP:  jmp_d = 1'b1;
      OP_JC:   jmp_d = flags_q.carry;
      OP_JNC:  jmp_d = !flags_q.carry;
      OP_JS:   jmp_d = flags_q.sign;
      OP_JNS:  jmp_d = !flags_q.sign;
      OP_JZ:   jmp_d = flags_q.zero;
      OP_JNZ:  jmp_d = !flags_q.zero;
      OP_JV:   jmp_d = flags_q.ovf;
      OP_JNV:  jmp_d = !flags_q.ovf;
      default: jmp_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (exec) begin
      if (ir.op == OP_STR)  dmem[daddr] <= ra_val;
      if (ir.op == OP_STIN) dmem[daddr] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      dout_q  <= '0;
      jmp_q   <= 1'b0;
    end else if (exec) begin
      if (alu_upd)         flags_q <= alu_fl;
      if (ir.op == OP_OUT) dout_q  <= dmem_rd;
      jmp_q <= jmp_d;
    end
  end

  mc16_ctrl #(.IA_W(IA_W), .DELAY_CYCLES(DELAY_CYCLES)) ctrl_i (
    .clk(clk), .rst(rst), .start(start),
    .is_halt(ir.op == OP_HALT), .jump_take(jmp_q),
    .jump_tgt(ir.imm[IA_W-1:0]),
    .state(st), .pc(pc), .halted(halted)
  );

  assign dout      = dout_q;
  assign flags     = flags_q;
  assign fsm_state = st;
endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk
  import mc16_pkg::*;
#(
  parameter int IA_W         = 4,
  parameter int DELAY_CYCLES = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [2:0]      st,
  input logic [IA_W-1:0] pc,
  input logic [XLEN-1:0] dout,
  input logic [3:0]      flags,
  input logic            halted
);
  localparam int            CW   = $clog2(DELAY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] dcnt;
  always_ff @(posedge clk) begin
    if (rst)                 dcnt <= '0;
    else if (st == ST_DELAY) dcnt <= dcnt + 1'b1;
    else                     dcnt <= '0;
  end

  // R2
  idle_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !start) |=> st == ST_IDLE);
  // R3
  fetch_exec_chk: assert property (@(posedge clk) disable iff (rst)
    st == ST_FETCH |=> st == ST_EXEC);
  // R3
  exec_delay_chk: assert property (@(posedge clk) disable iff (rst)
    st == ST_EXEC |=> st == ST_DELAY);
  // R3
  delay_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DELAY && dcnt < LAST) |=> st == ST_DELAY);
  // R3
  delay_end_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DELAY && dcnt == LAST) |=> st == ST_NEXT);
  // R3
  next_hchk_chk: assert property (@(posedge clk) disable iff (rst)
    st == ST_NEXT |=> st == ST_HCHK);
  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    st != ST_NEXT |=> $stable(pc));
  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    st != ST_EXEC |=> $stable(flags));
  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    st != ST_EXEC |=> $stable(dout));
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && st == ST_HCHK));
endmodule

bind mc16_core mc16_core_chk #(.IA_W(IA_W), .DELAY_CYCLES(DELAY_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .start(start), .st(fsm_state), .pc(pc),
  .dout(dout), .flags(flags), .halted(halted)
);

// File: tb/mc16_core_tb.sv
`timescale 1ns/1ps
module mc16_core_tb_top;
  localparam logic [4:0] MOVSPR = 5'd0,  MOV  = 5'd1,  ADD  = 5'd2,  SUB = 5'd3,
                         MUL    = 5'd4,  ANDO = 5'd6,  XORO = 5'd7,
                         NOR    = 5'd10, NOTO = 5'd11, STR  = 5'd12, STIN = 5'd13,
                         OUTO   = 5'd14, LDR  = 5'd15, JMP  = 5'd16, JC  = 5'd17,
                         JNC    = 5'd18, JZ   = 5'd21, HALT = 5'd31;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        imem_we = 1'b0;
  logic [3:0]  imem_addr = '0;
  logic [31:0] imem_wdata = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [3:0]  flags;
  logic [3:0]  pc;
  logic        halted;
  logic [2:0]  fsm_state;

  int checks = 0;
  int fails  = 0;
  logic [31:0] prog [16];

  always #2 clk = ~clk;

  mc16_core dut_i (
    .clk(clk), .rst(rst), .start(start), .imem_we(imem_we),
    .imem_addr(imem_addr), .imem_wdata(imem_wdata), .din(din),
    .dout(dout), .flags(flags), .pc(pc), .halted(halted), .fsm_state(fsm_state)
  );

  function automatic logic [31:0] ii(logic [4:0] op, logic [4:0] rd, logic [4:0] ra, logic [15:0] imm);
    return {op, rd, ra, 1'b1, imm};
  endfunction
  function automatic logic [31:0] rr(logic [4:0] op, logic [4:0] rd, logic [4:0] ra, logic [4:0] rb);
    return {op, rd, ra, 1'b0, rb, 11'd0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = ii(HALT, 5'd0, 5'd0, 16'd0);
  endtask

  task automatic load_prog();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = 4'(i); imem_wdata = prog[i];
    end
    @(negedge clk) imem_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic run_prog(string req);
    int n;
    do_reset();
    load_prog();
    pulse_start();
    n = 0;
    while (!halted && n < 400) begin @(negedge clk); n++; end
    chk(req, {31'd0, halted}, 32'd1, "halt reached");
  endtask

  task automatic t_reset();
    clear_prog();
    do_reset();
    chk("R1", {29'd0, fsm_state}, 32'd0, "state after reset");
    chk("R1", {28'd0, pc}, 32'd0, "pc after reset");
    chk("R1", {16'd0, dout}, 32'd0, "dout after reset");
    chk("R1", {28'd0, flags}, 32'd0, "flags after reset");
    chk("R1", {31'd0, halted}, 32'd0, "halted after reset");
    repeat (10) @(negedge clk);
    chk("R2", {29'd0, fsm_state}, 32'd0, "idle without start");
  endtask

  task automatic t_sequence();
    int exp_st [9] = '{1, 2, 3, 3, 3, 3, 4, 5, 1};
    clear_prog();
    prog[0] = ii(MOV, 5'd1, 5'd0, 16'd1);
    do_reset();
    load_prog();
    pulse_start();
    for (int i = 0; i < 9; i++) begin
      chk("R3", {29'd0, fsm_state}, 32'(exp_st[i]), $sformatf("state step %0d", i));
      if (i == 5) chk("R11", {28'd0, pc}, 32'd0, "pc held before next");
      if (i == 7) chk("R11", {28'd0, pc}, 32'd1, "pc incremented after next");
      @(negedge clk);
    end
  endtask

  task automatic t_add_imm();
    clear_prog();
    prog[0] = ii(MOV, 5'd1, 5'd0, 16'd5);
    prog[1] = ii(ADD, 5'd2, 5'd1, 16'd7);
    prog[2] = ii(STR, 5'd0, 5'd2, 16'd0);
    prog[3] = ii(OUTO, 5'd0, 5'd0, 16'd0);
    run_prog("R4");
    chk("R4", {16'd0, dout}, 32'd12, "add immediate");
    chk("R5", {28'd0, flags}, 32'h0, "flags after 5+7");
    chk("R10", {28'd0, pc}, 32'd4, "pc at halt address");
  endtask

  task automatic t_sub_reg();
    clear_prog();
    prog[0] = ii(MOV, 5'd1, 5'd0, 16'd3);
    prog[1] = ii(MOV, 5'd2, 5'd0, 16'd5);
    prog[2] = rr(SUB, 5'd3, 5'd1, 5'd2);
    prog[3] = ii(MOV, 5'd4, 5'd0, 16'd0);
    prog[4] = ii(STR, 5'd0, 5'd3, 16'd1);
    prog[5] = ii(OUTO, 5'd0, 5'd0, 16'd1);
    run_prog("R5");
    chk("R4", {16'd0, dout}, 32'hFFFE, "sub register mode");
    chk("R5", {28'd0, flags}, 32'h6, "borrow and sign");
    chk("R8", {28'd0, flags}, 32'h6, "mov leaves flags");
  endtask

  task automatic t_add_flags();
    clear_prog();
    prog[0] = ii(MOV, 5'd1, 5'd0, 16'h7FFF);
    prog[1] = ii(ADD, 5'd2, 5'd1, 16'd1);
    run_prog("R5");
    chk("R5", {28'd0, flags}, 32'hC, "signed overflow");
    clear_prog();
    prog[0] = ii(MOV, 5'd1, 5'd0, 16'hFFFF);
    prog[1] = ii(ADD, 5'd2, 5'd1, 16'd1);
    prog[2] = ii(STR, 5'd0, 5'd2, 16'd0);
    prog[3] = ii(OUTO, 5'd0, 5'd0, 16'd0);
    run_prog("R5");
    chk("R5", {28'd0, flags}, 32'h3, "carry and zero");
    chk("R5", {16'd0, dout}, 32'h0, "wrapped sum");
  endtask

  task automatic t_mul();
    clear_prog();
    prog[0] = ii(MOV, 5'd1, 5'd0, 16'h1234);
    prog[1] = ii(MUL, 5'd2, 5'd1, 16'h0100);
    prog[2] = ii(MOVSPR, 5'd3, 5'd0, 16'd0);
    prog[3] = ii(STR, 5'd0, 5'd3, 16'd2);
    prog[4] = ii(OUTO, 5'd0, 5'd0, 16'd2);
    run_prog("R6");
    chk("R6", {16'd0, dout}, 32'h0012, "product high half");
    chk("R6", {28'd0, flags}, 32'h2, "mul flags");
    clear_prog();
    prog[0] = ii(MOV, 5'd1, 5'd0, 16'h1234);
    prog[1] = ii(MUL, 5'd2, 5'd1, 16'h0100);
    prog[2] = ii(STR, 5'd0, 5'd2, 16'd2);
    prog[3] = ii(OUTO, 5'd0, 5'd0, 16'd2);
    run_prog("R6");
    chk("R6", {16'd0, dout}, 32'h3400, "product low half");
  endtask

  task automatic t_logic();
    clear_prog();
    prog[0] = ii(MOV, 5'd1, 5'd0, 16'h0F0F);
    prog[1] = ii(XORO, 5'd2, 5'd1, 16'h00FF);
    prog[2] = rr(NOR, 5'd3, 5'd2, 5'd1);
    prog[3] = rr(NOTO, 5'd4, 5'd0, 5'd3);
    prog[4] = ii(STR, 5'd0, 5'd4, 16'd5);
    prog[5] = ii(OUTO, 5'd0, 5'd0, 16'd5);
    run_prog("R7");
    chk("R7", {16'd0, dout}, 32'h0FFF, "xor nor not chain");
    chk("R7", {28'd0, flags}, 32'h0, "logic flags");
    clear_prog();
    prog[0] = ii(MOV, 5'd1, 5'd0, 16'hF0F0);
    prog[1] = ii(ANDO, 5'd2, 5'd1, 16'h0F0F);
    run_prog("R7");
    chk("R7", {28'd0, flags}, 32'h1, "and gives zero");
  endtask

  task automatic t_din();
    din = 16'hBEEF;
    clear_prog();
    prog[0] = ii(STIN, 5'd0, 5'd0, 16'd3);
    prog[1] = ii(LDR, 5'd1, 5'd0, 16'd3);
    prog[2] = ii(ADD, 5'd2, 5'd1, 16'd1);
    prog[3] = ii(STR, 5'd0, 5'd2, 16'd4);
    prog[4] = ii(OUTO, 5'd0, 5'd0, 16'd4);
    run_prog("R8");
    chk("R8", {16'd0, dout}, 32'hBEF0, "din through memory");
    chk("R5", {28'd0, flags}, 32'h4, "sign from add");
    din = '0;
  endtask

  task automatic t_jumps();
    clear_prog();
    prog[0]  = ii(MOV, 5'd1, 5'd0, 16'd1);
    prog[1]  = ii(SUB, 5'd2, 5'd1, 16'd1);
    prog[2]  = ii(JZ, 5'd0, 5'd0, 16'd5);
    prog[3]  = ii(MOV, 5'd3, 5'd0, 16'hAAAA);
    prog[5]  = ii(MOV, 5'd3, 5'd0, 16'h5555);
    prog[6]  = ii(JNC, 5'd0, 5'd0, 16'd9);
    prog[7]  = ii(MOV, 5'd3, 5'd0, 16'hAAAA);
    prog[9]  = ii(JC, 5'd0, 5'd0, 16'd12);
    prog[10] = ii(STR, 5'd0, 5'd3, 16'd0);
    prog[11] = ii(OUTO, 5'd0, 5'd0, 16'd0);
    run_prog("R9");
    chk("R9", {16'd0, dout}, 32'h5555, "taken and fallthrough jumps");
    chk("R9", {28'd0, pc}, 32'd12, "final pc after jumps");
    chk("R9", {28'd0, flags}, 32'h1, "jumps keep flags");
  endtask

  task automatic t_halt();
    logic [3:0] pc_h;
    clear_prog();
    prog[0] = ii(JMP, 5'd0, 5'd0, 16'd3);
    prog[1] = ii(MOV, 5'd1, 5'd0, 16'h1111);
    prog[3] = ii(MOV, 5'd1, 5'd0, 16'h2222);
    prog[4] = ii(STR, 5'd0, 5'd1, 16'd2);
    prog[5] = ii(OUTO, 5'd0, 5'd0, 16'd2);
    run_prog("R10");
    chk("R9", {16'd0, dout}, 32'h2222, "unconditional jump");
    pc_h = pc;
    chk("R10", {28'd0, pc_h}, 32'd6, "halt address");
    repeat (20) @(negedge clk);
    pulse_start();
    repeat (10) @(negedge clk);
    chk("R10", {29'd0, fsm_state}, 32'd5, "stays in halt check");
    chk("R10", {28'd0, pc}, {28'd0, pc_h}, "pc frozen");
    chk("R10", {31'd0, halted}, 32'd1, "halted sticky");
    chk("R11", {16'd0, dout}, 32'h2222, "dout unchanged after halt");
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_add_imm();
    t_sub_reg();
    t_add_flags();
    t_mul();
    t_logic();
    t_din();
    t_jumps();
    t_halt();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule